// File: doc/BRIEF.md
# Shift, Rotate and Bit-Test Unit

A purely combinational datapath slice for the prefixed 8-bit bit-manipulation group of a small processor core. Given an operand byte, an operation code, a bit index and the current flag nibble, it produces the new byte, a write-enable for that byte, and the four updated condition flags: zero, subtract, half-carry and carry. The operations are circular rotates, rotates through carry, an arithmetic left shift, arithmetic and logical right shifts, a nibble swap, and single-bit test, clear and set.

Fetching the operand and writing the result back are left to the surrounding core. It drives `result_we` and the flag outputs on every evaluation, and it commits them in the same cycle as the instruction. For any operation that keeps a flag unchanged, the unit passes that flag through from `flags_in`. The core can therefore always load all four flag outputs.

A separate input, `acc_short`, marks the short one-byte accumulator rotate forms. These forms report a zero flag of 0 no matter what the result is.

Top module: `bitops_unit`

## Requirements
- R1: Operation code 0 rotates circularly left and code 1 rotates circularly right. The bit that leaves one end enters the other end and is also copied to C.
- R2: Operation code 2 rotates left through carry and code 3 rotates right through carry. The old C (`flags_in[0]`) fills the vacated bit, and the bit that leaves goes to C.
- R3: Operation code 4 shifts left and fills bit 0 with 0. The old bit 7 goes to C.
- R4: Operation code 5 shifts right and keeps bit 7 unchanged. Operation code 6 shifts right and fills bit 7 with 0. In both cases the old bit 0 goes to C.
- R5: For codes 0 to 7, N and H are cleared and `result_we` is 1. Z is 1 exactly when the result is zero, except in the case covered by R6.
- R6: When `acc_short` is 1 and the code is 0 to 3, Z is 0 whatever the result is. For every other code, `acc_short` has no effect on any output.
- R7: Operation code 7 exchanges the high and low nibbles and clears C.
- R8: Operation code 8 tests bit `bit_idx`. Z is set when that bit is 0, N is cleared and H is set. C keeps `flags_in[0]`, `result_we` is 0 and `result` equals the operand.
- R9: Operation code 9 clears bit `bit_idx` and code 10 sets it. All other bits are kept, `result_we` is 1, and all four flags equal `flags_in`.
- R10: Codes 11 to 15 do nothing. `result_we` is 0, `result` equals the operand, and the flags equal `flags_in`.
- R11: The flag nibble is ordered {Z, N, H, C} from bit 3 down to bit 0, for both `flags_in` and the output flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 8 | Byte to operate on |
| op_sel | input | 4 | Operation code (0 to 10 defined) |
| bit_idx | input | 3 | Bit index for test, clear and set |
| flags_in | input | 4 | Current flags {Z,N,H,C}; bit 0 is carry-in |
| acc_short | input | 1 | Short accumulator rotate form |
| result | output | 8 | New byte value |
| result_we | output | 1 | Result must be written back |
| z_out | output | 1 | New zero flag |
| n_out | output | 1 | New subtract flag |
| h_out | output | 1 | New half-carry flag |
| c_out | output | 1 | New carry flag |

## Verification
The unit holds no state, so a fault in its decode or data paths appears at the outputs in the same evaluation as the input that triggers it. The bench applies every operation code with every bit index, with a spread of operand bytes, with all flag nibbles, and with both settings of the short-form input. It checks the byte, the write-enable and each flag against a behavioural model on every clock. A fault that affects only one bit position, such as a wrong index decode, a wrong fill bit or a misrouted carry, is caught within the first sweep of operands and indices.

// File: rtl/bitops_unit.sv
module bitops_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0]         operand,
  input  logic [3:0]           op_sel,
  input  logic [$clog2(W)-1:0] bit_idx,
  input  logic [3:0]           flags_in,
  input  logic                 acc_short,
  output logic [W-1:0]         result,
  output logic                 result_we,
  output logic                 z_out,
  output logic                 n_out,
  output logic                 h_out,
  output logic                 c_out
);
  localparam int HALF = W / 2;
  localparam logic [3:0] OP_ROLC = 4'd0, OP_RORC = 4'd1, OP_ROLT = 4'd2, OP_RORT = 4'd3,
                         OP_SHLA = 4'd4, OP_SHRA = 4'd5, OP_SHRL = 4'd6, OP_SWAP = 4'd7,
                         OP_TEST = 4'd8, OP_CLRB = 4'd9, OP_SETB = 4'd10;

  logic msb, lsb, cin;
  assign msb = operand[W-1];
  assign lsb = operand[0];
  assign cin = flags_in[0];

  always_comb begin
    result    = operand;
    result_we = 1'b0;
    {z_out, n_out, h_out, c_out} = flags_in;
    case (op_sel)
      OP_ROLC: begin result = {operand[W-2:0], msb};  c_out = msb; end
      OP_RORC: begin result = {lsb, operand[W-1:1]};  c_out = lsb; end
      OP_ROLT: begin result = {operand[W-2:0], cin};  c_out = msb; end
      OP_RORT: begin result = {cin, operand[W-1:1]};  c_out = lsb; end
      OP_SHLA: begin result = {operand[W-2:0], 1'b0}; c_out = msb; end
      OP_SHRA: begin result = {msb, operand[W-1:1]};  c_out = lsb; end
      OP_SHRL: begin result = {1'b0, operand[W-1:1]}; c_out = lsb; end
      OP_SWAP: begin result = {operand[HALF-1:0], operand[W-1:HALF]}; c_out = 1'b0; end
      OP_TEST: begin z_out = ~operand[bit_idx]; n_out = 1'b0; h_out = 1'b1; end
      OP_CLRB: begin result[bit_idx] = 1'b0; result_we = 1'b1; end
      OP_SETB: begin result[bit_idx] = 1'b1; result_we = 1'b1; end
      default: ;
    endcase
    if (op_sel <= OP_SWAP) begin
      result_we = 1'b1;
      n_out     = 1'b0;
      h_out     = 1'b0;
      z_out     = (result == '0) && !(acc_short && op_sel <= OP_RORT);
    end
  end

  always_comb begin
    if (!$isunknown({op_sel, operand, bit_idx, flags_in, acc_short})) begin
      if (op_sel <= OP_SHRL)
        p_shift_clears_nh_r5: assert (!n_out && !h_out && result_we);
      if (acc_short && op_sel <= OP_RORT)
        p_short_form_z_low_r6: assert (!z_out);
      if (op_sel == OP_TEST)
        p_test_keeps_byte_r8: assert (!result_we && result == operand && c_out == flags_in[0] && h_out);
      if (op_sel == OP_CLRB || op_sel == OP_SETB)
        p_bitop_flags_kept_r9: assert ({z_out, n_out, h_out, c_out} == flags_in
                                       && ((result ^ operand) & ~(W'(1) << bit_idx)) == '0);
      if (op_sel > OP_SETB)
        p_idle_codes_r10: assert (!result_we && result == operand
                                  && {z_out, n_out, h_out, c_out} == flags_in);
    end
  end
endmodule

// File: tb/bitops_unit_tb.sv
module bitops_unit_tb;
  logic       clk = 1'b0;
  logic [7:0] operand;
  logic [3:0] op_sel;
  logic [2:0] bit_idx;
  logic [3:0] flags_in;
  logic       acc_short;
  logic [7:0] result;
  logic       result_we, z_out, n_out, h_out, c_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  bitops_unit u_dut (
    .operand(operand), .op_sel(op_sel), .bit_idx(bit_idx), .flags_in(flags_in),
    .acc_short(acc_short), .result(result), .result_we(result_we),
    .z_out(z_out), .n_out(n_out), .h_out(h_out), .c_out(c_out)
  );

  function automatic string req_of(int op);
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R3";
      5, 6: return "R4";
      7: return "R7";
      8: return "R8";
      9, 10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_once(input int v, input int op, input int idx, input int fl, input int sh);
    int r, we, z, n, h, c, cin, pw;
    logic [12:0] got, exp;
    string tag;
    cin = fl % 2; pw = 1;
    for (int k = 0; k < idx; k++) pw = pw * 2;
    r = v; we = 0; z = (fl / 8) % 2; n = (fl / 4) % 2; h = (fl / 2) % 2; c = cin;
    tag = req_of(op);
    if (op <= 7) begin
      we = 1; n = 0; h = 0;
      case (op)
        0: begin c = v / 128; r = (v * 2) % 256 + c; end
        1: begin c = v % 2;   r = v / 2 + c * 128; end
        2: begin c = v / 128; r = (v * 2) % 256 + cin; end
        3: begin c = v % 2;   r = v / 2 + cin * 128; end
        4: begin c = v / 128; r = (v * 2) % 256; end
        5: begin c = v % 2;   r = v / 2 + (v / 128) * 128; end
        6: begin c = v % 2;   r = v / 2; end
        default: begin c = 0; r = (v % 16) * 16 + v / 16; end
      endcase
      z = (r == 0) ? 1 : 0;
      if (sh == 1 && op <= 3) begin z = 0; tag = {tag, "/R6"}; end
      else tag = {tag, "/R5"};
    end else if (op == 8) begin
      z = ((v / pw) % 2 == 0) ? 1 : 0; n = 0; h = 1;
    end else if (op == 9) begin
      we = 1; if ((v / pw) % 2 == 1) r = v - pw;
    end else if (op == 10) begin
      we = 1; if ((v / pw) % 2 == 0) r = v + pw;
    end
    exp = {r[7:0], we[0], z[0], n[0], h[0], c[0]};
    got = {result, result_we, z_out, n_out, h_out, c_out};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s/R11 op=%0d v=%02h idx=%0d fl=%h sh=%0d: got %h expected %h",
               tag, op, v, idx, fl, sh, got, exp);
    end
  endtask

  initial begin
    int vals[8] = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81};
    operand = 8'h00; op_sel = 4'd15; bit_idx = 3'd0; flags_in = 4'h0; acc_short = 1'b0;
    @(negedge clk);
    check_once(0, 15, 0, 0, 0);
    for (int op = 0; op < 16; op++)
      for (int idx = 0; idx < 8; idx++)
        for (int vi = 0; vi < 8; vi++)
          for (int fl = 0; fl < 16; fl++)
            for (int sh = 0; sh < 2; sh++) begin
              @(posedge clk);
              operand = vals[vi][7:0]; op_sel = op[3:0]; bit_idx = idx[2:0];
              flags_in = fl[3:0]; acc_short = sh[0];
              @(negedge clk);
              check_once(vals[vi], op, idx, fl, sh);
            end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule